// File: doc/BRIEF.md
# CAN Interrupt Source Identifier

This block gathers every interrupt source of a CAN controller into a single request line and a numeric code that tells software which source to service next. Two groups feed it: a controller-wide group (transfer successes, error-code updates, and changes of the warning and bus-off levels) and a bank of message objects, each of which reports completed transmissions and receptions. The controller-wide group always outranks the objects. Among the objects, a lower object number has higher priority.

Software talks to the block over a small register bus. Reading the status register acknowledges the controller-wide request. Writing the status register clears its event flags. A write to the clear register drops the pending bit of one object. The code register always shows the most urgent source still pending. One transfer can therefore raise two requests, a controller-wide one and an object one. These show up one after the other as software services them.

Top module: `can_irq_id`

## Requirements
- R1: Code 1 is shown whenever the controller-wide request is pending, whatever object bits are also pending.
- R2: With no controller-wide request, the code is n+1 for the lowest-numbered pending object n (objects 1..NUM_OBJ, so codes 2..NUM_OBJ+1).
- R3: Code 0 means nothing is pending. The code is 0 after reset, and the status register reads 0 after reset.
- R4: A controller-wide request is raised by a transmit-ok pulse, a receive-ok pulse or an error-code update, but only while statusIe is 1. The event flags are stored whatever the enable. Status layout: bits [2:0] last error code, bit 3 transmit-ok, bit 4 receive-ok, bit 5 zero, bit 6 warning level, bit 7 bus-off level.
- R5: A controller-wide request is also raised when warnFlag or busOffFlag differs from its value in the previous cycle, but only while errorIe is 1.
- R6: Object n becomes pending on its transmit-done pulse with its transmit enable set, or on its receive-done pulse with its receive enable set. Nothing else sets it.
- R7: irqOut is 1 exactly when globalIe is 1 and the code is not 0. globalIe does not change any pending state.
- R8: A read at address 0 clears the controller-wide request. A new raising event in the same cycle wins.
- R9: A write at address 0 loads the error code, transmit-ok and receive-ok from data bits [2:0], 3 and 4. A new event in the same cycle wins. The write does not touch the request.
- R10: A pending object stays pending while the controller-wide request is serviced, and its code appears once that request is cleared.
- R11: A write at address 2 with data[3:0] equal to n (1..NUM_OBJ) clears object n. A set in the same cycle wins. Other values clear nothing.
- R12: A read at address 1 returns the code in bits [4:0]. Address 3, and address 2 on read, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalIe | input | 1 | Master enable of the request line |
| statusIe | input | 1 | Enable of transfer and error-code requests |
| errorIe | input | 1 | Enable of level-change requests |
| evTxOk | input | 1 | Transmit-ok pulse |
| evRxOk | input | 1 | Receive-ok pulse |
| evLec | input | 1 | Error-code update pulse |
| lecCode | input | 3 | Error code carried by evLec |
| warnFlag | input | 1 | Warning level |
| busOffFlag | input | 1 | Bus-off level |
| objTxDone | input | NUM_OBJ | Per-object transmit-complete pulses, bit i is object i+1 |
| objRxDone | input | NUM_OBJ | Per-object receive-complete pulses |
| objTxIe | input | NUM_OBJ | Per-object transmit enables |
| objRxIe | input | NUM_OBJ | Per-object receive enables |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational |
| irqOut | output | 1 | Interrupt request |
| intId | output | ID_W | Current identifier code |

## Verification
The properties assume that busRd and busWr are never high together. They also assume that the level inputs stay low through reset, so change detection starts from a known state. The survival property relies on no clear write reaching the objects while a code of 2 or more is shown. The random stimulus keeps the two strobes exclusive and holds the levels at zero during reset. It draws clear writes only rarely, so the property's antecedent is met often. Every clear write still passes through the reference model.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int STAT_ADDR  = 0;
  localparam int ID_ADDR    = 1;
  localparam int CLR_ADDR   = 2;
  localparam int BIT_TXOK   = 3;
  localparam int BIT_RXOK   = 4;
  localparam int BIT_WARN   = 6;
  localparam int BIT_BOFF   = 7;

  typedef struct packed {
    logic       rdStatus;
    logic       wrStatus;
    logic       clrObj;
    logic [3:0] clrIdx;
  } irqStrobe_t;
endpackage

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output irqStrobe_t        strobe
);
  always_comb begin
    strobe.rdStatus = busRd && (busAddr == ADDR_W'(STAT_ADDR));
    strobe.wrStatus = busWr && (busAddr == ADDR_W'(STAT_ADDR));
    strobe.clrObj   = busWr && (busAddr == ADDR_W'(CLR_ADDR));
    strobe.clrIdx   = busWdata[3:0];
  end
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
  parameter int NUM_OBJ = 15,
  parameter int ID_W    = 5
) (
  input  logic               statReq,
  input  logic [NUM_OBJ-1:0] pend,
  output logic [ID_W-1:0]    code
);
  logic [ID_W-1:0] objCode;
  always_comb begin
    objCode = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend[i]) objCode = ID_W'(i + 2);
    end
    code = statReq ? ID_W'(1) : objCode;
  end
endmodule

// File: rtl/can_irq_datapath.sv
module can_irq_datapath
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int ID_W    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               statusIe,
  input  logic               errorIe,
  input  logic               evTxOk,
  input  logic               evRxOk,
  input  logic               evLec,
  input  logic [2:0]         lecCode,
  input  logic               warnFlag,
  input  logic               busOffFlag,
  input  logic [NUM_OBJ-1:0] objTxDone,
  input  logic [NUM_OBJ-1:0] objRxDone,
  input  logic [NUM_OBJ-1:0] objTxIe,
  input  logic [NUM_OBJ-1:0] objRxIe,
  input  irqStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [ID_W-1:0]    code
);
  logic               statReq;
  logic               txOk;
  logic               rxOk;
  logic [2:0]         lec;
  logic               prevWarn;
  logic               prevBoff;
  logic [NUM_OBJ-1:0] pend;
  logic               statEvent;
  logic               errEvent;
  logic [DATA_W-1:0]  statusWord;

  assign statEvent = statusIe && (evTxOk || evRxOk || evLec);
  assign errEvent  = errorIe && ((warnFlag ^ prevWarn) || (busOffFlag ^ prevBoff));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReq  <= 1'b0;
      txOk     <= 1'b0;
      rxOk     <= 1'b0;
      lec      <= '0;
      prevWarn <= 1'b0;
      prevBoff <= 1'b0;
    end else begin
      prevWarn <= warnFlag;
      prevBoff <= busOffFlag;
      if (statEvent || errEvent) statReq <= 1'b1;
      else if (strobe.rdStatus)  statReq <= 1'b0;
      if (evTxOk)               txOk <= 1'b1;
      else if (strobe.wrStatus) txOk <= wrData[BIT_TXOK];
      if (evRxOk)               rxOk <= 1'b1;
      else if (strobe.wrStatus) rxOk <= wrData[BIT_RXOK];
      if (evLec)                lec <= lecCode;
      else if (strobe.wrStatus) lec <= wrData[2:0];
    end
  end

  for (genvar g = 0; g < NUM_OBJ; g++) begin : gObj
    logic setObj;
    logic clrHit;
    assign setObj = (objTxDone[g] && objTxIe[g]) || (objRxDone[g] && objRxIe[g]);
    assign clrHit = strobe.clrObj && (strobe.clrIdx == 4'(g + 1));
    always_ff @(posedge clk) begin
      if (!rstN)       pend[g] <= 1'b0;
      else if (setObj) pend[g] <= 1'b1;
      else if (clrHit) pend[g] <= 1'b0;
    end
  end

  can_irq_prio #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) u_prio (
    .statReq(statReq),
    .pend   (pend),
    .code   (code)
  );

  always_comb begin
    statusWord = '0;
    statusWord[2:0]      = lec;
    statusWord[BIT_TXOK] = txOk;
    statusWord[BIT_RXOK] = rxOk;
    statusWord[BIT_WARN] = warnFlag;
    statusWord[BIT_BOFF] = busOffFlag;
    case (rdAddr)
      ADDR_W'(STAT_ADDR): rdData = statusWord;
      ADDR_W'(ID_ADDR):   rdData = DATA_W'(code);
      default:            rdData = '0;
    endcase
  end
endmodule

// File: rtl/can_irq_id.sv
module can_irq_id
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  localparam int ID_W   = $clog2(NUM_OBJ + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalIe,
  input  logic               statusIe,
  input  logic               errorIe,
  input  logic               evTxOk,
  input  logic               evRxOk,
  input  logic               evLec,
  input  logic [2:0]         lecCode,
  input  logic               warnFlag,
  input  logic               busOffFlag,
  input  logic [NUM_OBJ-1:0] objTxDone,
  input  logic [NUM_OBJ-1:0] objRxDone,
  input  logic [NUM_OBJ-1:0] objTxIe,
  input  logic [NUM_OBJ-1:0] objRxIe,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic [ID_W-1:0]    intId
);
  irqStrobe_t strobe;

  can_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strobe  (strobe)
  );

  can_irq_datapath #(
    .NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .statusIe  (statusIe),
    .errorIe   (errorIe),
    .evTxOk    (evTxOk),
    .evRxOk    (evRxOk),
    .evLec     (evLec),
    .lecCode   (lecCode),
    .warnFlag  (warnFlag),
    .busOffFlag(busOffFlag),
    .objTxDone (objTxDone),
    .objRxDone (objRxDone),
    .objTxIe   (objTxIe),
    .objRxIe   (objRxIe),
    .strobe    (strobe),
    .wrData    (busWdata),
    .rdAddr    (busAddr),
    .rdData    (busRdata),
    .code      (intId)
  );

  assign irqOut = globalIe && (intId != '0);
endmodule

// File: rtl/can_irq_id_chk.sv
module can_irq_id_chk #(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W  = 2,
  parameter int ID_W    = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              globalIe,
  input logic              errorIe,
  input logic              evTxOk,
  input logic              evRxOk,
  input logic              evLec,
  input logic              busRd,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              irqOut,
  input logic [ID_W-1:0]   intId
);
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    intId <= ID_W'(NUM_OBJ + 1)); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !globalIe |-> !irqOut); // R7

  AST_IRQ_NEEDS_ID: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (intId != '0)); // R3

  AST_STAT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == '0 && !evTxOk && !evRxOk && !evLec && !errorIe)
      |=> (intId != ID_W'(1))); // R8

  AST_OBJ_SURVIVES: assert property (@(posedge clk) disable iff (!rstN)
    (intId >= ID_W'(2) && !(busWr && busAddr == ADDR_W'(2)))
      |=> (intId != '0 && intId <= $past(intId))); // R10

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R12
endmodule

bind can_irq_id can_irq_id_chk #(
  .NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .globalIe(globalIe),
  .errorIe (errorIe),
  .evTxOk  (evTxOk),
  .evRxOk  (evRxOk),
  .evLec   (evLec),
  .busRd   (busRd),
  .busWr   (busWr),
  .busAddr (busAddr),
  .irqOut  (irqOut),
  .intId   (intId)
);

// File: tb/can_irq_id_tb.sv
module can_irq_id_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_OBJ = 15;
  localparam int ID_W = 5;

  logic clk = 0;
  logic rstN = 0;
  logic globalIe = 0, statusIe = 0, errorIe = 0;
  logic evTxOk = 0, evRxOk = 0, evLec = 0;
  logic [2:0] lecCode = 0;
  logic warnFlag = 0, busOffFlag = 0;
  logic [NUM_OBJ-1:0] objTxDone = 0, objRxDone = 0, objTxIe = 0, objRxIe = 0;
  logic busRd = 0, busWr = 0;
  logic [1:0] busAddr = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic irqOut;
  logic [ID_W-1:0] intId;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit mStat;
  bit [NUM_OBJ-1:0] mPend;
  bit mTx, mRx, mPw, mPb;
  bit [2:0] mLec;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_id u_dut (
    .clk(clk), .rstN(rstN), .globalIe(globalIe), .statusIe(statusIe),
    .errorIe(errorIe), .evTxOk(evTxOk), .evRxOk(evRxOk), .evLec(evLec),
    .lecCode(lecCode), .warnFlag(warnFlag), .busOffFlag(busOffFlag),
    .objTxDone(objTxDone), .objRxDone(objRxDone), .objTxIe(objTxIe),
    .objRxIe(objRxIe), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .intId(intId)
  );

  function automatic logic [ID_W-1:0] expId();
    if (mStat) return 1;
    for (int i = 0; i < NUM_OBJ; i++) if (mPend[i]) return ID_W'(i + 2);
    return 0;
  endfunction

  function automatic logic [7:0] expStatus();
    return {busOffFlag, warnFlag, 1'b0, mRx, mTx, mLec};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    evTxOk = 0; evRxOk = 0; evLec = 0; objTxDone = 0; objRxDone = 0;
    busRd = 0; busWr = 0; busAddr = 0; busWdata = 0;
  endtask

  // One clock: check read data, advance model, compare code and line.
  task automatic cycle(string req);
    bit statEv, errEv;
    bit [NUM_OBJ-1:0] nPend;
    #1;
    if (busRd) begin
      if (busAddr == 0) chk({req, " R4 status read"}, busRdata, expStatus());
      else if (busAddr == 1) chk({req, " R12 id read"}, busRdata, {3'b0, expId()});
      else chk({req, " R12 spare read"}, busRdata, 0);
    end
    statEv = statusIe && (evTxOk || evRxOk || evLec);
    errEv = errorIe && ((warnFlag != mPw) || (busOffFlag != mPb));
    for (int i = 0; i < NUM_OBJ; i++) begin
      if ((objTxDone[i] && objTxIe[i]) || (objRxDone[i] && objRxIe[i])) nPend[i] = 1;
      else if (busWr && busAddr == 2 && busWdata[3:0] == 4'(i + 1)) nPend[i] = 0;
      else nPend[i] = mPend[i];
    end
    @(posedge clk);
    mPend = nPend;
    if (statEv || errEv) mStat = 1;
    else if (busRd && busAddr == 0) mStat = 0;
    if (evTxOk) mTx = 1; else if (busWr && busAddr == 0) mTx = busWdata[3];
    if (evRxOk) mRx = 1; else if (busWr && busAddr == 0) mRx = busWdata[4];
    if (evLec) mLec = lecCode; else if (busWr && busAddr == 0) mLec = busWdata[2:0];
    mPw = warnFlag; mPb = busOffFlag;
    #1;
    chk({req, " R1 R2 id"}, intId, expId());
    chk({req, " R7 irq"}, irqOut, globalIe && (expId() != 0));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset id", intId, 0);
    chk("R3 reset irq", irqOut, 0);
    busRd = 1; busAddr = 0; #1;
    chk("R3 reset status", busRdata, 0);
    busRd = 0;
    rstN = 1;
    globalIe = 1; statusIe = 1; errorIe = 1;
    objTxIe = '1; objRxIe = 15'h00F0;
    cycle("R3 idle");

    // R4: transmit-ok raises code 1
    evTxOk = 1; cycle("R4 txok");
    idle();
    chk("R4 code after txok", intId, 1);
    // R1/R10: object 3 completes while status pending
    objTxDone[2] = 1; cycle("R1 obj under status"); idle();
    chk("R1 status outranks", intId, 1);
    busRd = 1; busAddr = 0; cycle("R8 status read"); idle();
    chk("R10 object surfaces", intId, 4);
    // R6: object without receive enable
    objRxDone[0] = 1; cycle("R6 disabled rx"); idle();
    chk("R6 no spurious", intId, 4);
    // R2: lower object wins
    objTxDone[1] = 1; cycle("R2 obj2"); idle();
    chk("R2 lowest wins", intId, 3);
    busWr = 1; busAddr = 2; busWdata = 8'd2; cycle("R11 clear obj2"); idle();
    chk("R11 after clear", intId, 4);
    busWr = 1; busAddr = 2; busWdata = 8'd0; cycle("R11 clear zero"); idle();
    chk("R11 index 0 ignored", intId, 4);
    // R11: set wins over clear
    objTxDone[2] = 1; busWr = 1; busAddr = 2; busWdata = 8'd3; cycle("R11 set wins"); idle();
    chk("R11 set beats clear", intId, 4);
    // R7: global enable masks line only
    globalIe = 0; cycle("R7 masked");
    chk("R7 line low", irqOut, 0);
    globalIe = 1; cycle("R7 unmasked");
    chk("R7 line back", irqOut, 1);
    busWr = 1; busAddr = 2; busWdata = 8'd3; cycle("R11 clear obj3"); idle();
    chk("R3 all clear", intId, 0);
    // R5: warning change with and without enable
    errorIe = 0; warnFlag = 1; cycle("R5 masked change");
    chk("R5 no request", intId, 0);
    errorIe = 1; busOffFlag = 1; cycle("R5 boff change");
    chk("R5 request", intId, 1);
    busRd = 1; busAddr = 0; cycle("R8 ack"); idle();
    // R4: status disabled, flags still stored
    statusIe = 0; evRxOk = 1; evLec = 1; lecCode = 3'd5; cycle("R4 gated"); idle();
    chk("R4 gated no request", intId, 0);
    busRd = 1; busAddr = 0; cycle("R4 flags kept"); idle();
    // R9: software write clears flags
    busWr = 1; busAddr = 0; busWdata = 8'h00; cycle("R9 write status"); idle();
    busRd = 1; busAddr = 0; cycle("R9 flags cleared"); idle();
    chk("R9 status zero bits", busRdata & 8'h1F, 0);
    warnFlag = 0; busOffFlag = 0; cycle("R5 settle"); 
    busRd = 1; busAddr = 0; cycle("R8 settle ack"); idle();

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      globalIe = ($urandom % 8) != 0;
      statusIe = ($urandom % 4) != 0;
      errorIe  = ($urandom % 4) != 0;
      if (n % 64 == 0) begin objTxIe = NUM_OBJ'($urandom); objRxIe = NUM_OBJ'($urandom); end
      evTxOk = ($urandom % 16) == 0;
      evRxOk = ($urandom % 16) == 0;
      evLec  = ($urandom % 16) == 0;
      lecCode = 3'($urandom);
      if (($urandom % 32) == 0) warnFlag = ~warnFlag;
      if (($urandom % 48) == 0) busOffFlag = ~busOffFlag;
      if (($urandom % 6) == 0) objTxDone = NUM_OBJ'(1) << ($urandom % NUM_OBJ);
      if (($urandom % 6) == 0) objRxDone = NUM_OBJ'(1) << ($urandom % NUM_OBJ);
      r = $urandom % 10;
      if (r < 3) begin busRd = 1; busAddr = 2'($urandom); end
      else if (r < 4) begin busWr = 1; busAddr = 2'($urandom); busWdata = 8'($urandom % 17); end
      cycle("R1 R2 R4 R5 R6 R8 R11 random");
    end
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule